// File: doc/BRIEF.md
# Lane Execute-Directive Sequencer

This block is the execution-control stage of one processing lane. It takes execute directives one at a time from an upstream queue. Each directive names a starting index into the lane's instruction-block cache and says whether the block is to be run for every virtual processor (VP) hosted by the lane (broadcast) or for one VP only (single). The sequencer walks the block one instruction word per issued micro-operation. It tags each micro-operation with the global number of the VP it runs for, and hands it to the lane's single shared functional unit, which serves all of the lane's VPs in turn.

In broadcast mode the whole block runs for one VP. At the end-of-block word the sequencer rewinds to the start index for the next VP. VPs are visited in ascending local slot order. Global VP numbers are interleaved across lanes, so local slot `s` on lane `L` is VP `s*NUM_LANES + L`. When an instruction asks for a thread fetch, its target index and the VP number are handed back to the command front end in the same cycle as the micro-operation is issued. The micro-operation waits until the front end can take the request.

Top module: `lane_exec_seq`

## Requirements
- R1: `dir_ready` is high exactly when no directive is in progress. A directive is taken on a clock edge where `dir_valid` and `dir_ready` are both high. From the next cycle `dir_ready` is low and `cache_addr` equals the directive's `dir_idx`.
- R2: Instruction word format: bit INSTR_W-1 is end-of-block, bit INSTR_W-2 requests a thread fetch, and bits IDX_W-1:0 hold the thread-fetch target index. `iss_instr` is the cache word at `cache_addr`. After an issued word without end-of-block, `cache_addr` advances by one, wrapping modulo 2^IDX_W.
- R3: A broadcast directive (`dir_bcast`=1) runs the complete block for slot 0, then rewinds to `dir_idx` for slot 1, and so on up to slot VPS-1.
- R4: A single directive (`dir_bcast`=0) runs the block once, only for slot `dir_slot`.
- R5: `iss_vp` and `tf_vp` equal slot*NUM_LANES + `lane_id`.
- R6: For a word with the thread-fetch bit set, `tf_valid` is raised with `tf_vp`=`iss_vp` and `tf_addr`=word bits IDX_W-1:0. The issue and the thread-fetch handshakes complete in the same cycle. `tf_valid` is low for all other words.
- R7: While a thread-fetch word meets `tf_ready` low, `iss_valid` stays low and `cache_addr` holds.
- R8: While `iss_valid` is high and `iss_ready` is low, `cache_addr` and `iss_vp` hold.
- R9: In the cycle after the end-of-block word of the last VP is issued, `dir_ready` is high and `iss_valid` is low. `iss_valid` and `tf_valid` stay low while idle.
- R10: During and after reset the block is idle: `dir_ready`=1, `iss_valid`=0, `tf_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_id | input | LANE_W | Constant number of this lane |
| dir_valid | input | 1 | Directive offered |
| dir_ready | output | 1 | Sequencer idle, directive taken |
| dir_bcast | input | 1 | 1: all lane VPs, 0: one VP |
| dir_slot | input | SLOT_W | Local slot for a single directive |
| dir_idx | input | IDX_W | Block start index in the cache |
| cache_addr | output | IDX_W | Instruction cache read index |
| cache_rdata | input | INSTR_W | Instruction word at `cache_addr` (same cycle) |
| iss_valid | output | 1 | Micro-operation offered |
| iss_ready | input | 1 | Functional unit takes it |
| iss_vp | output | VP_W | Global VP number of the micro-operation |
| iss_instr | output | INSTR_W | Instruction word issued |
| tf_valid | output | 1 | Thread-fetch request offered |
| tf_ready | input | 1 | Front end takes the request |
| tf_vp | output | VP_W | VP that requested the fetch |
| tf_addr | output | IDX_W | Next block index for that VP |

## Verification
The cache read is combinational, so an issued micro-operation and any thread-fetch request belong to the same cycle as the word at `cache_addr`. A new index appears one edge after a handshake. The first index of a directive appears one edge after acceptance, and `dir_ready` returns one edge after the final handshake. The bench changes the ready inputs just after each rising edge and samples every output at the falling edge. It compares each handshake, in order, against an arithmetically built list of (VP, word) pairs. It checks the first index and the idle return exactly one falling edge after the edge that causes them. Directed phases hold one ready input low for several cycles and check that index, VP and valid flags stay frozen.

// File: rtl/lane_exec_pkg.sv
package lane_exec_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  typedef struct packed {
    logic eob;
    logic tfetch;
  } iflags_t;
endpackage

// File: rtl/lane_exec_vpmap.sv
module lane_exec_vpmap #(
  parameter int VPS   = 4,
  parameter int LANES = 4,
  localparam int SLOT_W = (VPS > 1) ? $clog2(VPS) : 1,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int VP_W   = ((VPS * LANES) > 1) ? $clog2(VPS * LANES) : 1
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [LANE_W-1:0] lane,
  output logic [VP_W-1:0]   vp
);
  localparam bit LANES_POW2 = (LANES > 1) && ((LANES & (LANES - 1)) == 0);

  generate
    if (LANES_POW2) begin : g_concat
      localparam int CW = SLOT_W + LANE_W;
      logic [CW-1:0] joined;
      assign joined = {slot, lane};
      assign vp = VP_W'(joined);
    end else begin : g_mult
      int unsigned prod;
      assign prod = int'(slot) * LANES + int'(lane);
      assign vp = VP_W'(prod);
    end
  endgenerate
endmodule

// File: rtl/lane_exec_issue.sv
module lane_exec_issue
  import lane_exec_pkg::*;
(
  input  logic    run,
  input  iflags_t fl,
  input  logic    iss_ready,
  input  logic    tf_ready,
  output logic    iss_valid,
  output logic    tf_valid,
  output logic    fire
);
  // A thread-fetch word goes out only when the front end can take it too,
  // so both handshakes complete on the same edge.
  assign iss_valid = run && (!fl.tfetch || tf_ready);
  assign tf_valid  = run && fl.tfetch && iss_ready;
  assign fire      = iss_valid && iss_ready;
endmodule

// File: rtl/lane_exec_ctrl.sv
module lane_exec_ctrl
  import lane_exec_pkg::*;
#(
  parameter int VPS   = 4,
  parameter int IDX_W = 6,
  localparam int SLOT_W = (VPS > 1) ? $clog2(VPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_valid,
  input  logic              dir_bcast,
  input  logic [SLOT_W-1:0] dir_slot,
  input  logic [IDX_W-1:0]  dir_idx,
  input  logic              fire,
  input  logic              eob,
  output logic              dir_ready,
  output logic              run,
  output logic [IDX_W-1:0]  pc,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(VPS - 1);

  phase_e            ph_q, ph_d;
  logic              bc_q, bc_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [IDX_W-1:0]  pc_q, pc_d;
  logic [IDX_W-1:0]  base_q, base_d;
  logic              accept;
  logic              ld;

  always_comb begin
    ph_d   = ph_q;
    bc_d   = bc_q;
    slot_d = slot_q;
    pc_d   = pc_q;
    base_d = base_q;
    accept = dir_valid && (ph_q == PH_IDLE);
    if (accept) begin
      ph_d   = PH_RUN;
      bc_d   = dir_bcast;
      slot_d = dir_bcast ? '0 : dir_slot;
      pc_d   = dir_idx;
      base_d = dir_idx;
    end else if (fire) begin
      if (!eob) begin
        pc_d = pc_q + 1'b1;
      end else if (bc_q && (slot_q != SLOT_LAST)) begin
        slot_d = slot_q + 1'b1;
        pc_d   = base_q;
      end else begin
        ph_d = PH_IDLE;
      end
    end
  end

  assign ld = accept || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bc_q   <= 1'b0;
      slot_q <= '0;
      pc_q   <= '0;
      base_q <= '0;
    end else if (ld) begin
      ph_q   <= ph_d;
      bc_q   <= bc_d;
      slot_q <= slot_d;
      pc_q   <= pc_d;
      base_q <= base_d;
    end
  end

  assign dir_ready = (ph_q == PH_IDLE);
  assign run       = (ph_q == PH_RUN);
  assign pc        = pc_q;
  assign slot      = slot_q;

  // R9: the issue stage may only hand over a micro-operation while running
  p_fire_only_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (ph_q == PH_RUN));

  // R3: finishing a non-last VP of a broadcast stays busy on the next slot
  p_next_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && eob && bc_q && (slot_q != SLOT_LAST)) |=>
      (ph_q == PH_RUN) && (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/lane_exec_seq.sv
module lane_exec_seq
  import lane_exec_pkg::*;
#(
  parameter int VPS     = 4,
  parameter int LANES   = 4,
  parameter int IDX_W   = 6,
  parameter int INSTR_W = 16,
  localparam int SLOT_W = (VPS > 1) ? $clog2(VPS) : 1,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int VP_W   = ((VPS * LANES) > 1) ? $clog2(VPS * LANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANE_W-1:0]  lane_id,
  input  logic               dir_valid,
  output logic               dir_ready,
  input  logic               dir_bcast,
  input  logic [SLOT_W-1:0]  dir_slot,
  input  logic [IDX_W-1:0]   dir_idx,
  output logic [IDX_W-1:0]   cache_addr,
  input  logic [INSTR_W-1:0] cache_rdata,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [VP_W-1:0]    iss_vp,
  output logic [INSTR_W-1:0] iss_instr,
  output logic               tf_valid,
  input  logic               tf_ready,
  output logic [VP_W-1:0]    tf_vp,
  output logic [IDX_W-1:0]   tf_addr
);
  logic              run;
  logic              fire;
  logic [SLOT_W-1:0] slot;
  logic [VP_W-1:0]   vp;
  iflags_t           fl;

  assign fl = '{eob: cache_rdata[INSTR_W-1], tfetch: cache_rdata[INSTR_W-2]};

  lane_exec_ctrl #(.VPS(VPS), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_valid (dir_valid),
    .dir_bcast (dir_bcast),
    .dir_slot  (dir_slot),
    .dir_idx   (dir_idx),
    .fire      (fire),
    .eob       (fl.eob),
    .dir_ready (dir_ready),
    .run       (run),
    .pc        (cache_addr),
    .slot      (slot)
  );

  lane_exec_issue u_issue (
    .run       (run),
    .fl        (fl),
    .iss_ready (iss_ready),
    .tf_ready  (tf_ready),
    .iss_valid (iss_valid),
    .tf_valid  (tf_valid),
    .fire      (fire)
  );

  lane_exec_vpmap #(.VPS(VPS), .LANES(LANES)) u_vpmap (
    .slot (slot),
    .lane (lane_id),
    .vp   (vp)
  );

  assign iss_vp    = vp;
  assign tf_vp     = vp;
  assign iss_instr = cache_rdata;
  assign tf_addr   = cache_rdata[IDX_W-1:0];

  // R1: accepted directive starts at its own index and blocks further ones
  p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && dir_ready) |=> (!dir_ready && (cache_addr == $past(dir_idx))));

  // R2: a word without end-of-block moves the read index up by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !cache_rdata[INSTR_W-1]) |=>
      (cache_addr == IDX_W'($past(cache_addr) + 1'b1)));

  // R6: a thread-fetch request is only offered together with a taken issue
  p_tf_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tf_valid |-> (iss_ready && (tf_vp == iss_vp)));

  // R7: while nothing is issued during a directive the read index holds
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_ready && !iss_valid) |=> $stable(cache_addr));

  // R8: back-pressure from the functional unit freezes index and VP
  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> ($stable(cache_addr) && $stable(iss_vp)));

  // R9: nothing is offered while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_ready |-> (!iss_valid && !tf_valid));
endmodule

// File: tb/test_lane_exec_seq.sv
module test_lane_exec_seq;
  localparam int VPS     = 4;
  localparam int LANES   = 4;
  localparam int IDX_W   = 6;
  localparam int INSTR_W = 16;
  localparam int SLOT_W  = 2;
  localparam int LANE_W  = 2;
  localparam int VP_W    = 4;
  localparam int DEPTH   = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [LANE_W-1:0]  lane_id;
  logic               dir_valid, dir_ready, dir_bcast;
  logic [SLOT_W-1:0]  dir_slot;
  logic [IDX_W-1:0]   dir_idx;
  logic [IDX_W-1:0]   cache_addr;
  logic [INSTR_W-1:0] cache_rdata;
  logic               iss_valid, iss_ready;
  logic [VP_W-1:0]    iss_vp;
  logic [INSTR_W-1:0] iss_instr;
  logic               tf_valid, tf_ready;
  logic [VP_W-1:0]    tf_vp;
  logic [IDX_W-1:0]   tf_addr;

  logic [INSTR_W-1:0] mem [DEPTH];
  assign cache_rdata = mem[cache_addr];

  int checks = 0;
  int failures = 0;
  int rmode = 0;
  int cyc = 0;
  logic [VP_W-1:0]    exp_vp [64];
  logic [INSTR_W-1:0] exp_ins [64];
  int exp_wr = 0;
  int exp_rd = 0;
  bit chk_retire = 1'b0;
  string cur_tag = "R3";

  lane_exec_seq i_lane_exec_seq (
    .clk(clk), .rst_n(rst_n), .lane_id(lane_id),
    .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_bcast(dir_bcast),
    .dir_slot(dir_slot), .dir_idx(dir_idx),
    .cache_addr(cache_addr), .cache_rdata(cache_rdata),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_vp(iss_vp),
    .iss_instr(iss_instr), .tf_valid(tf_valid), .tf_ready(tf_ready),
    .tf_vp(tf_vp), .tf_addr(tf_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [INSTR_W-1:0] word(int s, int i, int n, int tfpos);
    logic [INSTR_W-1:0] w;
    w = INSTR_W'((s * 37 + i * 11 + 5) & 16'h3fff);
    w[INSTR_W-1] = (i == n - 1);
    w[INSTR_W-2] = (i == tfpos);
    return w;
  endfunction

  // ready inputs change just after the rising edge
  initial begin
    iss_ready = 1'b0;
    tf_ready  = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      case (rmode)
        0: begin iss_ready = 1'b1; tf_ready = 1'b1; end
        1: begin iss_ready = (cyc % 2) == 0; tf_ready = 1'b1; end
        2: begin iss_ready = (cyc % 3) != 0; tf_ready = (cyc % 4) != 1; end
        3: begin iss_ready = 1'b1; tf_ready = 1'b0; end
        default: begin iss_ready = 1'b0; tf_ready = 1'b1; end
      endcase
    end
  end

  // handshake monitor at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (chk_retire) begin
          check(dir_ready && !iss_valid, "R9", "idle one cycle after last op",
                int'({dir_ready, iss_valid}), 2);
          chk_retire = 1'b0;
        end
        if (iss_valid && iss_ready) begin
          if (exp_rd >= exp_wr) begin
            check(1'b0, cur_tag, "issue beyond expected list", int'(iss_instr), 0);
          end else begin
            check(iss_vp == exp_vp[exp_rd], {cur_tag, "/R5"}, "VP number",
                  int'(iss_vp), int'(exp_vp[exp_rd]));
            check(iss_instr == exp_ins[exp_rd], "R2", "instruction word",
                  int'(iss_instr), int'(exp_ins[exp_rd]));
            if (exp_ins[exp_rd][INSTR_W-2]) begin
              check(tf_valid && tf_ready && tf_vp == exp_vp[exp_rd] &&
                    tf_addr == exp_ins[exp_rd][IDX_W-1:0], "R6", "thread-fetch return",
                    int'({tf_valid, tf_ready, tf_vp, tf_addr}),
                    int'({2'b11, exp_vp[exp_rd], exp_ins[exp_rd][IDX_W-1:0]}));
            end else begin
              check(!tf_valid, "R6", "no thread fetch on plain word", int'(tf_valid), 0);
            end
            if (exp_rd + 1 == exp_wr) chk_retire = 1'b1;
            exp_rd++;
          end
        end
      end
    end
  end

  // call at a falling edge; leaves the directive accepted, at a falling edge
  task automatic start_dir(input int lane, input bit bc, input int slot,
                           input int s, input int n, input int tfpos);
    while (!dir_ready) @(negedge clk);
    for (int i = 0; i < n; i++) mem[(s + i) % DEPTH] = word(s, i, n, tfpos);
    exp_wr = 0;
    exp_rd = 0;
    for (int v = 0; v < VPS; v++) begin
      if (bc || v == slot) begin
        for (int i = 0; i < n; i++) begin
          exp_vp[exp_wr]  = VP_W'(v * LANES + lane);
          exp_ins[exp_wr] = word(s, i, n, tfpos);
          exp_wr++;
        end
      end
    end
    cur_tag   = bc ? "R3" : "R4";
    lane_id   = LANE_W'(lane);
    dir_bcast = bc;
    dir_slot  = SLOT_W'(slot);
    dir_idx   = IDX_W'(s % DEPTH);
    dir_valid = 1'b1;
    @(negedge clk);
    dir_valid = 1'b0;
    check(!dir_ready && cache_addr == IDX_W'(s % DEPTH), "R1", "first read index",
          int'({dir_ready, cache_addr}), s % DEPTH);
  endtask

  task automatic wait_done();
    while (exp_rd < exp_wr || !dir_ready) @(negedge clk);
    @(negedge clk);
    check(exp_rd == exp_wr, cur_tag, "all expected ops issued", exp_rd, exp_wr);
  endtask

  task automatic run_dir(input int lane, input bit bc, input int slot,
                         input int s, input int n, input int tfpos);
    start_dir(lane, bc, slot, s, n, tfpos);
    wait_done();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", exp_rd, exp_wr);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lane_id = '0; dir_valid = 1'b0; dir_bcast = 1'b0; dir_slot = '0; dir_idx = '0;
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    // R10: idle state under reset
    check(dir_ready && !iss_valid && !tf_valid, "R10", "reset state",
          int'({dir_ready, iss_valid, tf_valid}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(dir_ready && !iss_valid && !tf_valid, "R10", "state after reset release",
          int'({dir_ready, iss_valid, tf_valid}), 4);

    // sweep: lanes, ready patterns, block lengths, broadcast and every single slot
    for (int ln = 0; ln < LANES; ln++) begin
      for (int m = 0; m < 3; m++) begin
        rmode = m;
        for (int n = 1; n <= 4; n++) begin
          int s;
          int tp;
          s  = (ln * 13 + m * 7 + n * 5) % DEPTH;
          tp = (n + ln) % (n + 1);
          run_dir(ln, 1'b1, 0, s, n, tp);
          for (int sl = 0; sl < VPS; sl++) run_dir(ln, 1'b0, sl, s, n, (tp + sl) % (n + 1));
        end
      end
    end

    // R2: block that wraps past the top of the index space
    rmode = 0;
    run_dir(1, 1'b1, 0, 62, 4, 1);

    // R7: thread-fetch word with the front end not ready
    rmode = 3;
    start_dir(2, 1'b0, 1, 10, 2, 0);
    for (int k = 0; k < 4; k++) begin
      check(!iss_valid && tf_valid && cache_addr == IDX_W'(10), "R7",
            "stall on busy thread-fetch return",
            int'({iss_valid, tf_valid, cache_addr}), int'({1'b0, 1'b1, 6'd10}));
      @(negedge clk);
    end
    rmode = 0;
    wait_done();

    // R8: functional unit back-pressure
    rmode = 4;
    start_dir(3, 1'b1, 0, 20, 3, 3);
    for (int k = 0; k < 4; k++) begin
      check(iss_valid && iss_vp == VP_W'(3) && cache_addr == IDX_W'(20), "R8",
            "hold under back-pressure",
            int'({iss_valid, iss_vp, cache_addr}), int'({1'b1, 4'd3, 6'd20}));
      @(negedge clk);
    end
    rmode = 1;
    wait_done();

    // R4/R5: last slot on last lane, single word with fetch
    rmode = 2;
    run_dir(3, 1'b0, 3, 40, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule